// File: doc/BRIEF.md
# Byte-Addressed Load/Store Lane Unit

This unit sits between a 32-bit core and a data memory that is one word wide. For each request it adds the base register value to the sign-extended 16-bit offset. It then drives a word address, a per-lane byte-enable mask and lane-aligned write data to the memory. It handles byte, halfword and word accesses, both signed and unsigned. Within a word the bytes are ordered big-endian: the lowest address lands in the most significant lane.

The memory is synchronous, so read data comes back in the cycle after the request. The unit keeps a note of the size, lane and extension of each issued load. In the response cycle it uses that note to pick the byte or halfword out of the returned word and extend it to 32 bits. A request whose address is not aligned to its size is flagged on `misalign` and does not reach the memory. No trap is raised.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is `reqBase` plus `reqOffset` sign-extended to 32 bits. `memWordAddr` is the effective address with its low two bits removed.
- R2: Opcodes are 0x20 signed byte load, 0x24 unsigned byte load, 0x21 signed halfword load, 0x25 unsigned halfword load, 0x23 word load, 0x28 byte store, 0x29 halfword store and 0x2B word store. Any other opcode, or `reqValid` low, gives `memEn`=0, `memWe`=0 and `misalign`=0.
- R3: Byte order is big-endian. A byte access at address offset a (a = effective address bits [1:0]) uses lane 3-a: byte-enable bit 3-a and data bits [31-8a:24-8a]. A byte store asserts only that enable and puts `reqStoreData[7:0]` on all four lanes.
- R4: A halfword access with address bit 1 = 0 enables 4'b1100; with bit 1 = 1 it enables 4'b0011. A halfword store puts `reqStoreData[15:0]` on both halves.
- R5: A word access enables 4'b1111. A word store passes `reqStoreData` through unchanged.
- R6: `misalign` is 1 for a halfword access at an odd address, or a word access whose address bits [1:0] are not zero. In that case `memEn` and `memWe` are 0. A byte access is never misaligned.
- R7: An issued load drives `memEn`=1 and `memWe`=0 together with the byte enables of the lanes it reads. `loadValid` is 1 in the following cycle only, and `memRdData` is taken in that cycle.
- R8: Signed byte and halfword loads sign-extend the selected subword. Unsigned byte and halfword loads zero-extend it.
- R9: A word load returns `memRdData` unchanged. `loadData` is 0 whenever `loadValid` is 0.
- R10: While `rstN` is low and directly after reset, `loadValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 6 | Access opcode |
| reqBase | input | 32 | Base register value |
| reqOffset | input | 16 | Signed address offset |
| reqStoreData | input | 32 | Store source register value |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write strobe |
| memWordAddr | output | 30 | Word address |
| memByteEn | output | 4 | Byte-lane enables, bit 3 = most significant lane |
| memWrData | output | 32 | Lane-aligned write data |
| memRdData | input | 32 | Read word, valid one cycle after a load |
| misalign | output | 1 | Request address not aligned to its size |
| loadValid | output | 1 | Load result present |
| loadData | output | 32 | Extended load result |

## Verification
The bench stores a word, then reads back bytes at offsets 0 and 3 and halfwords at offsets 0 and 2. A little-endian or mirrored lane mapping would return the wrong end of the word, for example 0x05 at byte 8 after a word store of 5. Signed and unsigned subword loads are run on bytes with the top bit set and clear, so a sign/zero extension mix-up shows up in the upper bits. Misaligned halfword and word requests, including stores, must not write: a design that still writes would corrupt a word that is read back afterwards. Negative offsets and unknown opcodes check that the offset is sign-extended and that undefined codes make no access.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam logic [5:0] OP_LD_BYTE_S = 6'h20;
  localparam logic [5:0] OP_LD_HALF_S = 6'h21;
  localparam logic [5:0] OP_LD_WORD   = 6'h23;
  localparam logic [5:0] OP_LD_BYTE_U = 6'h24;
  localparam logic [5:0] OP_LD_HALF_U = 6'h25;
  localparam logic [5:0] OP_ST_BYTE   = 6'h28;
  localparam logic [5:0] OP_ST_HALF   = 6'h29;
  localparam logic [5:0] OP_ST_WORD   = 6'h2B;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_t;

  typedef struct packed {
    logic     accessEn;
    logic     writeEn;
    logic     signExt;
    accSize_t size;
  } accStrobe_t;
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int LANE_BITS = 2
) (
  input  logic                 reqValid,
  input  logic [5:0]           reqOp,
  input  logic [LANE_BITS-1:0] addrLow,
  output accStrobe_t           strb,
  output logic                 misalign
);
  logic     known;
  logic     isStore;
  logic     signedLd;
  accSize_t size;
  logic     badAlign;

  always_comb begin
    known    = 1'b1;
    isStore  = 1'b0;
    signedLd = 1'b0;
    size     = SZ_WORD;
    case (reqOp)
      OP_LD_BYTE_S: begin size = SZ_BYTE; signedLd = 1'b1; end
      OP_LD_BYTE_U: size = SZ_BYTE;
      OP_LD_HALF_S: begin size = SZ_HALF; signedLd = 1'b1; end
      OP_LD_HALF_U: size = SZ_HALF;
      OP_LD_WORD:   size = SZ_WORD;
      OP_ST_BYTE:   begin size = SZ_BYTE; isStore = 1'b1; end
      OP_ST_HALF:   begin size = SZ_HALF; isStore = 1'b1; end
      OP_ST_WORD:   begin size = SZ_WORD; isStore = 1'b1; end
      default:      known = 1'b0;
    endcase
  end

  always_comb begin
    case (size)
      SZ_HALF: badAlign = addrLow[0];
      SZ_WORD: badAlign = (addrLow != '0);
      default: badAlign = 1'b0;
    endcase
  end

  assign misalign      = reqValid && known && badAlign;
  assign strb.accessEn = reqValid && known && !badAlign;
  assign strb.writeEn  = reqValid && known && !badAlign && isStore;
  assign strb.signExt  = signedLd;
  assign strb.size     = size;
endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int OFFSET_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  accStrobe_t                  strb,
  input  logic [DATA_W-1:0]           reqBase,
  input  logic [OFFSET_W-1:0]         reqOffset,
  input  logic [DATA_W-1:0]           reqStoreData,
  output logic [$clog2(DATA_W/8)-1:0] addrLow,
  output logic [DATA_W-$clog2(DATA_W/8)-1:0] memWordAddr,
  output logic [DATA_W/8-1:0]         memByteEn,
  output logic [DATA_W-1:0]           memWrData,
  input  logic [DATA_W-1:0]           memRdData,
  output logic                        loadValid,
  output logic [DATA_W-1:0]           loadData
);
  localparam int LANES     = DATA_W / 8;
  localparam int HALVES    = LANES / 2;
  localparam int LANE_BITS = $clog2(LANES);

  logic [DATA_W-1:0] effAddr;
  assign effAddr     = reqBase + {{(DATA_W-OFFSET_W){reqOffset[OFFSET_W-1]}}, reqOffset};
  assign addrLow     = effAddr[LANE_BITS-1:0];
  assign memWordAddr = effAddr[DATA_W-1:LANE_BITS];

  // Lane i holds bits [8i+7:8i]; big-endian byte offset of that lane is LANES-1-i.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic byteHit;
    logic halfHit;
    assign byteHit = (addrLow == LANE_BITS'(LANES - 1 - i));
    assign halfHit = (addrLow[LANE_BITS-1:1] == (LANE_BITS-1)'((LANES - 1 - i) / 2));
    always_comb begin
      case (strb.size)
        SZ_BYTE: memByteEn[i] = strb.accessEn && byteHit;
        SZ_HALF: memByteEn[i] = strb.accessEn && halfHit;
        default: memByteEn[i] = strb.accessEn;
      endcase
    end
  end

  always_comb begin
    case (strb.size)
      SZ_BYTE: memWrData = {LANES{reqStoreData[7:0]}};
      SZ_HALF: memWrData = {HALVES{reqStoreData[15:0]}};
      default: memWrData = reqStoreData;
    endcase
  end

  // Load response bookkeeping for the synchronous memory.
  logic                 respValid;
  logic                 respSigned;
  accSize_t             respSize;
  logic [LANE_BITS-1:0] respLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respSigned <= 1'b0;
      respSize   <= SZ_WORD;
      respLow    <= '0;
    end else begin
      respValid  <= strb.accessEn && !strb.writeEn;
      respSigned <= strb.signExt;
      respSize   <= strb.size;
      respLow    <= addrLow;
    end
  end

  logic [DATA_W-1:0] byteShifted;
  logic [DATA_W-1:0] halfShifted;
  logic [7:0]        pickByte;
  logic [15:0]       pickHalf;

  always_comb begin
    byteShifted = memRdData >> (8 * (LANES - 1 - int'(respLow)));
    halfShifted = memRdData >> (16 * (HALVES - 1 - int'(respLow[LANE_BITS-1:1])));
    pickByte    = byteShifted[7:0];
    pickHalf    = halfShifted[15:0];
    if (!respValid) begin
      loadData = '0;
    end else begin
      case (respSize)
        SZ_BYTE: loadData = {{(DATA_W-8){respSigned && pickByte[7]}}, pickByte};
        SZ_HALF: loadData = {{(DATA_W-16){respSigned && pickHalf[15]}}, pickHalf};
        default: loadData = memRdData;
      endcase
    end
  end
  assign loadValid = respValid;

  assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accessEn && strb.size == SZ_BYTE) |-> $countones(memByteEn) == 1);
  assert_half_two_lanes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accessEn && strb.size == SZ_HALF) |-> (memByteEn == 4'b1100 || memByteEn == 4'b0011));
  assert_word_all_lanes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accessEn && strb.size == SZ_WORD) |-> memByteEn == '1);
  assert_unsigned_byte_upper_R8: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && respSize == SZ_BYTE && !respSigned) |-> loadData[DATA_W-1:8] == '0);
  assert_idle_data_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |-> loadData == '0);
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int OFFSET_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [5:0]                  reqOp,
  input  logic [DATA_W-1:0]           reqBase,
  input  logic [OFFSET_W-1:0]         reqOffset,
  input  logic [DATA_W-1:0]           reqStoreData,
  output logic                        memEn,
  output logic                        memWe,
  output logic [DATA_W-$clog2(DATA_W/8)-1:0] memWordAddr,
  output logic [DATA_W/8-1:0]         memByteEn,
  output logic [DATA_W-1:0]           memWrData,
  input  logic [DATA_W-1:0]           memRdData,
  output logic                        misalign,
  output logic                        loadValid,
  output logic [DATA_W-1:0]           loadData
);
  localparam int LANE_BITS = $clog2(DATA_W / 8);

  accStrobe_t           strb;
  logic [LANE_BITS-1:0] addrLow;

  lsu_ctrl #(.LANE_BITS(LANE_BITS)) i_ctrl (
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .addrLow  (addrLow),
    .strb     (strb),
    .misalign (misalign)
  );

  lsu_datapath #(.DATA_W(DATA_W), .OFFSET_W(OFFSET_W)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqBase      (reqBase),
    .reqOffset    (reqOffset),
    .reqStoreData (reqStoreData),
    .addrLow      (addrLow),
    .memWordAddr  (memWordAddr),
    .memByteEn    (memByteEn),
    .memWrData    (memWrData),
    .memRdData    (memRdData),
    .loadValid    (loadValid),
    .loadData     (loadData)
  );

  assign memEn = strb.accessEn;
  assign memWe = strb.writeEn;

  assert_misalign_no_access_R6: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (!memEn && !memWe && memByteEn == '0));
  assert_idle_no_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!memEn && !misalign));
  assert_load_follows_issue_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |=> loadValid);
  assert_no_spurious_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(memEn && !memWe) |=> !loadValid);
endmodule

// File: tb/test_lsu_lane_unit.sv
module test_lsu_lane_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [5:0]  reqOp = '0;
  logic [31:0] reqBase = '0;
  logic [15:0] reqOffset = '0;
  logic [31:0] reqStoreData = '0;
  logic        memEn, memWe, misalign, loadValid;
  logic [29:0] memWordAddr;
  logic [3:0]  memByteEn;
  logic [31:0] memWrData, memRdData, loadData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lsu_lane_unit i_lsu_lane_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqBase(reqBase), .reqOffset(reqOffset), .reqStoreData(reqStoreData),
    .memEn(memEn), .memWe(memWe), .memWordAddr(memWordAddr),
    .memByteEn(memByteEn), .memWrData(memWrData), .memRdData(memRdData),
    .misalign(misalign), .loadValid(loadValid), .loadData(loadData)
  );

  // Bench memory: 16 words, synchronous read, byte-enabled write.
  logic [31:0] mem [16];
  logic [31:0] rdWord;
  assign memRdData = rdWord;
  always @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < 16; w++) mem[w] <= '0;
      rdWord <= '0;
    end else if (memEn) begin
      if (memWe) begin
        for (int b = 0; b < 4; b++)
          if (memByteEn[b]) mem[memWordAddr[3:0]][8*b +: 8] <= memWrData[8*b +: 8];
      end else begin
        rdWord <= mem[memWordAddr[3:0]];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] op, input logic [31:0] base, input logic [15:0] off,
                       input logic [31:0] sd);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqBase = base; reqOffset = off; reqStoreData = sd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
    #1;
  endtask

  task automatic doStore(input logic [5:0] op, input logic [31:0] addr, input logic [31:0] sd,
                         input logic [3:0] expBe, input logic [31:0] expWd, input string tag);
    drive(op, addr, 16'h0000, sd);
    check(memEn && memWe && !misalign, {tag, " store strobes"}, {29'd0, memEn, memWe, misalign}, 32'h6);
    check(memByteEn == expBe, {tag, " byte enables"}, {28'd0, memByteEn}, {28'd0, expBe});
    check(memWrData == expWd, {tag, " write data"}, memWrData, expWd);
    idle();
  endtask

  task automatic doLoad(input logic [5:0] op, input logic [31:0] addr, input logic [3:0] expBe,
                        input logic [31:0] expData, input string tag);
    drive(op, addr, 16'h0000, 32'hDEAD_BEEF);
    check(memEn && !memWe && memByteEn == expBe, {tag, " R7 load issue"},
          {26'd0, memEn, memWe, memByteEn}, {26'd0, 2'b10, expBe});
    idle();
    check(loadValid == 1'b1, {tag, " R7 loadValid"}, {31'd0, loadValid}, 32'd1);
    check(loadData == expData, {tag, " load data"}, loadData, expData);
    check(1'b1, "", 0, 0);
    checks--;
  endtask

  task automatic testReset();
    check(loadValid == 1'b0 && loadData == 32'd0, "R10 reset loadValid/data", loadData, 32'd0);
  endtask

  task automatic testAddress();
    // R1: positive and negative offsets, word address = EA >> 2
    drive(6'h23, 32'h1234_5678, 16'h0008, 32'd0);
    check(memWordAddr == 30'h048D15A0, "R1 word addr +8", {2'b0, memWordAddr}, 32'h048D15A0);
    drive(6'h23, 32'h1234_5678, 16'hFFFC, 32'd0);
    check(memWordAddr == 30'h048D159D, "R1 word addr -4", {2'b0, memWordAddr}, 32'h048D159D);
    idle();
  endtask

  task automatic testWordStoreNegOffset();
    // base 0x20, offset -0x20 -> EA 0
    drive(6'h2B, 32'h0000_0020, 16'hFFE0, 32'h80F1_7F01);
    check(memWordAddr == 30'd0, "R1 negative offset word address", {2'b0, memWordAddr}, 32'd0);
    check(memByteEn == 4'hF && memWrData == 32'h80F1_7F01, "R5 word store lanes/data", memWrData, 32'h80F1_7F01);
    idle();
  endtask

  task automatic testSubwordLoads();
    doLoad(6'h20, 32'd0, 4'b1000, 32'hFFFF_FF80, "R8 R3 LB off0");
    doLoad(6'h24, 32'd0, 4'b1000, 32'h0000_0080, "R8 LBU off0");
    doLoad(6'h20, 32'd2, 4'b0010, 32'h0000_007F, "R8 R3 LB off2");
    doLoad(6'h24, 32'd3, 4'b0001, 32'h0000_0001, "R3 LBU off3");
    doLoad(6'h21, 32'd0, 4'b1100, 32'hFFFF_80F1, "R8 R4 LH off0");
    doLoad(6'h25, 32'd0, 4'b1100, 32'h0000_80F1, "R8 LHU off0");
    doLoad(6'h21, 32'd2, 4'b0011, 32'h0000_7F01, "R4 LH off2");
    doLoad(6'h23, 32'd0, 4'b1111, 32'h80F1_7F01, "R9 LW");
  endtask

  task automatic testBigEndianExample();
    doStore(6'h2B, 32'd8, 32'h0000_0005, 4'b1111, 32'h0000_0005, "R5 SW 5 at 8");
    doLoad(6'h20, 32'd8, 4'b1000, 32'h0000_0000, "R3 LB at 8");
    doLoad(6'h20, 32'd11, 4'b0001, 32'h0000_0005, "R3 LB at 11");
  endtask

  task automatic testSubwordStores();
    doStore(6'h28, 32'd2, 32'h1234_56AB, 4'b0010, 32'hABAB_ABAB, "R3 SB at 2");
    doLoad(6'h20, 32'd2, 4'b0010, 32'hFFFF_FFAB, "R3 R8 LB reload at 2");
    doLoad(6'h23, 32'd0, 4'b1111, 32'h80F1_AB01, "R3 only lane touched");
    doStore(6'h29, 32'd6, 32'h7777_BEEF, 4'b0011, 32'hBEEF_BEEF, "R4 SH at 6");
    doStore(6'h29, 32'd4, 32'h0000_1234, 4'b1100, 32'h1234_1234, "R4 SH at 4");
    doLoad(6'h23, 32'd4, 4'b1111, 32'h1234_BEEF, "R4 halves placed");
  endtask

  task automatic testMisalign();
    drive(6'h21, 32'd1, 16'h0000, 32'd0);
    check(misalign && !memEn && !memWe, "R6 LH odd", {29'd0, misalign, memEn, memWe}, 32'h4);
    drive(6'h2B, 32'd2, 16'h0000, 32'hFFFF_FFFF);
    check(misalign && !memEn && !memWe, "R6 SW off2", {29'd0, misalign, memEn, memWe}, 32'h4);
    drive(6'h29, 32'd3, 16'h0000, 32'hFFFF_FFFF);
    check(misalign && !memEn && !memWe, "R6 SH off3", {29'd0, misalign, memEn, memWe}, 32'h4);
    drive(6'h23, 32'd1, 16'h0000, 32'd0);
    check(misalign && !memEn, "R6 LW off1", {30'd0, misalign, memEn}, 32'h2);
    idle();
    check(!loadValid, "R7 R6 no response after misaligned load", {31'd0, loadValid}, 32'd0);
    drive(6'h28, 32'd3, 16'h0000, 32'h0000_0011);
    check(!misalign && memEn, "R6 byte never misaligned", {30'd0, misalign, memEn}, 32'h1);
    idle();
    doLoad(6'h23, 32'd0, 4'b1111, 32'h80F1_AB11, "R6 word intact after misaligned stores");
  endtask

  task automatic testUnknownAndIdle();
    drive(6'h22, 32'd1, 16'h0000, 32'd0);
    check(!memEn && !memWe && !misalign, "R2 unknown opcode", {29'd0, memEn, memWe, misalign}, 32'd0);
    @(negedge clk);
    reqValid = 1'b0; reqOp = 6'h2B; reqBase = 32'd0; reqStoreData = 32'hFFFF_FFFF;
    #1;
    check(!memEn && !memWe && !misalign, "R2 reqValid low", {29'd0, memEn, memWe, misalign}, 32'd0);
    idle();
    check(!loadValid && loadData == 32'd0, "R9 idle loadData zero", loadData, 32'd0);
    doLoad(6'h23, 32'd0, 4'b1111, 32'h80F1_AB11, "R2 no write from invalid store");
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testAddress();
    testWordStoreNegOffset();
    testSubwordLoads();
    testBigEndianExample();
    testSubwordStores();
    testMisalign();
    testUnknownAndIdle();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule